// File: doc/BRIEF.md
# Misalignment-Aware Load/Store Front End

This block sits between a processor core and a memory port that is one 32-bit word wide. The core presents a byte address, an operand size of 1, 2, 4 or 8 bytes, a read or write flag and, for writes, the operand value. The block turns that request into one or more word accesses with byte enables and returns the assembled read value or finishes the write. Two configuration inputs are sampled with every request. One picks how misaligned requests are handled: they either raise a trap or are split into several word accesses. The other picks whether byte lanes within a word follow little-endian or big-endian placement.

The core raises `req_valid` and holds its request fields steady until the block answers with a one-cycle `req_done` or `trap_valid` pulse. The core then drops `req_valid` before the next clock edge. The memory side uses a request/acknowledge pair. `mem_req` stays high with a fixed address, enables and write data until `mem_ack` is seen. A split operand spans the fewest consecutive words that cover its bytes: two words, or three for an 8-byte operand that does not start on a word boundary.

Top module: `amu_access`

## Requirements
- R1: The size code on `req_size` is 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 8. A request of s bytes at address A counts as misaligned exactly when A mod s is not 0, so a single byte is never misaligned and an 8-byte operand at a multiple of 4 that is not a multiple of 8 is misaligned.
- R2: With `cfg_split` low, a misaligned request produces `trap_valid` for exactly one cycle. The pulse comes in the cycle after the request is taken, `trap_addr` then equals the request address, and no memory request is issued for it.
- R3: With `cfg_split` high, a misaligned request is served by the fewest word accesses that cover its bytes. The word at the lowest address goes first, and each later access is 4 bytes higher.
- R4: A request of 1, 2 or 4 bytes that is aligned uses one word access in either mode. `req_done` rises two cycles after `mem_req` rises when memory acknowledges after one cycle, which is three clock edges after the request is taken.
- R5: An aligned 8-byte request always uses two word accesses.
- R6: In little-endian mode the byte at address a travels in lane a mod 4 (bits 8*(a mod 4)+7 down to 8*(a mod 4)), and the operand's least significant byte sits at the lowest address.
- R7: In big-endian mode the byte at address a travels in lane 3 - (a mod 4), and the operand's most significant byte sits at the lowest address.
- R8: Every word access enables exactly the lanes whose bytes belong to the operand, so memory bytes just outside the operand keep their values.
- R9: `req_done` is a one-cycle pulse, one cycle after the acknowledge of the last access. For reads, `req_rdata` then holds the operand right-aligned and zero-extended to 64 bits.
- R10: While `mem_req` waits for `mem_ack`, `mem_addr` and `mem_be` stay unchanged, however long the acknowledge takes.
- R11: During and straight after reset, `mem_req`, `req_done` and `trap_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_split | input | 1 | 1: split misaligned requests, 0: trap on them |
| cfg_big_end | input | 1 | 1: big-endian lane placement, 0: little-endian |
| req_valid | input | 1 | Core request present, held until done or trap |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Operand size code (see R1) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 64 | Store operand, right-aligned |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 64 | Load result, zero-extended |
| trap_valid | output | 1 | One-cycle misalignment trap pulse |
| trap_addr | output | ADDR_W | Faulting address, valid with `trap_valid` |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | Word access is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Write word, unused lanes zero |
| mem_ack | input | 1 | Memory acknowledge, one cycle per access |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |

## Verification
The bench's memory model acknowledges each access one cycle after it sees the request, so one access costs two cycles. Results are therefore due at a known count of falling edges after the request is driven. A trap appears at the first edge, and a completion appears at edge 1 + 2n for n accesses. Each scenario counts falling edges until a pulse appears and compares that count with the value derived from the access count. In one scenario the acknowledge is held back by three extra cycles, which makes each access five cycles long. The memory model records the address and enables of every access, and the bench compares those records and the memory bytes only after the completion pulse.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam int WORD_BYTES = 4;
  localparam int OPND_BYTES = 8;
  localparam int LANE_IDX_W = $clog2(OPND_BYTES);
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_DONE,
    ST_TRAP
  } amu_state_e;

  // operand length in bytes for a size code
  function automatic logic [3:0] size_bytes(acc_size_e sz);
    return 4'd1 << sz;
  endfunction

  // low address bits under the size mask must all be zero
  function automatic logic is_misaligned(logic [2:0] lo, acc_size_e sz);
    logic [3:0] mask;
    mask = size_bytes(sz) - 4'd1;
    return ({1'b0, lo} & mask) != 4'd0;
  endfunction

  // number of words touched, counted from the word holding the first byte
  function automatic logic [1:0] beat_count(logic [1:0] off, acc_size_e sz);
    logic [3:0] last;
    last = {2'b00, off} + size_bytes(sz) - 4'd1;
    return last[3:2] + 2'd1;
  endfunction

endpackage

// File: rtl/amu_align_chk.sv
module amu_align_chk
  import amu_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  acc_size_e  size,
  output logic       misalign,
  output logic [1:0] n_beats
);

  always_comb begin
    misalign = is_misaligned(addr_lo, size);
    n_beats  = beat_count(addr_lo[1:0], size);
  end

  // an aligned operand narrower than 8 bytes must fit one word
  always_comb begin
    if (!misalign && size != SZ_DBL)
      AST_ALIGNED_ONE_BEAT: assert (n_beats == 2'd1); // R4
  end

endmodule

// File: rtl/amu_lane_map.sv
module amu_lane_map
  import amu_pkg::*;
(
  input  logic [OFF_W-1:0]                         off,
  input  acc_size_e                                size,
  input  logic [1:0]                               beat,
  input  logic                                     big_end,
  input  logic [8*OPND_BYTES-1:0]                  wdata,
  output logic [WORD_BYTES-1:0]                    be,
  output logic [8*WORD_BYTES-1:0]                  lane_wdata,
  output logic [WORD_BYTES-1:0][LANE_IDX_W-1:0]    opnd_idx
);

  // For every lane: byte position inside the word, then position
  // relative to the operand start, then operand byte number.
  always_comb begin
    for (int l = 0; l < WORD_BYTES; l++) begin
      int pos;
      int rel;
      int nb;
      int oi;
      pos = big_end ? (WORD_BYTES - 1 - l) : l;
      rel = WORD_BYTES * int'(beat) + pos - int'(off);
      nb  = int'(size_bytes(size));
      oi  = big_end ? (nb - 1 - rel) : rel;
      be[l] = (rel >= 0) && (rel < nb);
      opnd_idx[l] = be[l] ? LANE_IDX_W'(oi) : '0;
      lane_wdata[8*l +: 8] = be[l] ? wdata[8*opnd_idx[l] +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/amu_rd_merge.sv
module amu_rd_merge
  import amu_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clear,
  input  logic                                  capture,
  input  logic [WORD_BYTES-1:0]                 be,
  input  logic [WORD_BYTES-1:0][LANE_IDX_W-1:0] idx,
  input  logic [8*WORD_BYTES-1:0]               word,
  output logic [8*OPND_BYTES-1:0]               data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
    end else if (clear) begin
      data <= '0;
    end else if (capture) begin
      for (int l = 0; l < WORD_BYTES; l++) begin
        if (be[l]) data[8*idx[l] +: 8] <= word[8*l +: 8];
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> data == '0); // R9

endmodule

// File: rtl/amu_access.sv
module amu_access
  import amu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split,
  input  logic              cfg_big_end,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              req_done,
  output logic [63:0]       req_rdata,
  output logic              trap_valid,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  localparam int WADDR_W = ADDR_W - OFF_W;

  amu_state_e                            state_q;
  logic [ADDR_W-1:0]                     addr_q;
  acc_size_e                             size_q;
  logic                                  we_q;
  logic [63:0]                           wdata_q;
  logic                                  bend_q;
  logic [1:0]                            beat_q;
  logic [1:0]                            nbeat_q;

  // named internal events
  logic                                  req_misalign;
  logic [1:0]                            req_nbeats;
  logic                                  accept;
  logic                                  take_trap;
  logic                                  beat_ack;
  logic                                  last_beat;
  logic [WORD_BYTES-1:0]                 lane_be;
  logic [8*WORD_BYTES-1:0]               lane_wd;
  logic [WORD_BYTES-1:0][LANE_IDX_W-1:0] lane_idx;

  amu_align_chk u_chk (
    .addr_lo  (req_addr[2:0]),
    .size     (acc_size_e'(req_size)),
    .misalign (req_misalign),
    .n_beats  (req_nbeats)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign take_trap = accept && req_misalign && !cfg_split;
  assign beat_ack  = (state_q == ST_ACC) && mem_ack;
  assign last_beat = (beat_q == nbeat_q - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wdata_q <= '0;
      bend_q  <= 1'b0;
      beat_q  <= '0;
      nbeat_q <= 2'd1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            size_q  <= acc_size_e'(req_size);
            we_q    <= req_write;
            wdata_q <= req_wdata;
            bend_q  <= cfg_big_end;
            beat_q  <= '0;
            nbeat_q <= req_nbeats;
            state_q <= take_trap ? ST_TRAP : ST_ACC;
          end
        end
        ST_ACC: begin
          if (beat_ack) begin
            if (last_beat) state_q <= ST_DONE;
            else           beat_q  <= beat_q + 2'd1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_TRAP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  amu_lane_map u_lanes (
    .off        (addr_q[OFF_W-1:0]),
    .size       (size_q),
    .beat       (beat_q),
    .big_end    (bend_q),
    .wdata      (wdata_q),
    .be         (lane_be),
    .lane_wdata (lane_wd),
    .opnd_idx   (lane_idx)
  );

  amu_rd_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (beat_ack && !we_q),
    .be      (lane_be),
    .idx     (lane_idx),
    .word    (mem_rdata),
    .data    (req_rdata)
  );

  assign mem_req    = (state_q == ST_ACC);
  assign mem_we     = we_q;
  assign mem_addr   = {addr_q[ADDR_W-1:OFF_W] + WADDR_W'(beat_q), {OFF_W{1'b0}}};
  assign mem_be     = lane_be;
  assign mem_wdata  = lane_wd;
  assign req_done   = (state_q == ST_DONE);
  assign trap_valid = (state_q == ST_TRAP);
  assign trap_addr  = addr_q;

  AST_TRAP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !mem_req); // R2
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R9
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(mem_ack)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be))); // R10
  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 4'b0000)); // R8
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && !last_beat) |=> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES))); // R3
  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_done && trap_valid)); // R2

endmodule

// File: tb/amu_access_test.sv
module amu_access_test;

  localparam int AW   = 32;
  localparam int HALF = 10;   // 20 time units per period, 50 MHz

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_split = 1'b0, cfg_big_end = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          req_done, trap_valid;
  logic [63:0]   req_rdata;
  logic [AW-1:0] trap_addr;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;

  always #HALF clk = ~clk;

  amu_access #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_big_end(cfg_big_end),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .req_rdata(req_rdata), .trap_valid(trap_valid), .trap_addr(trap_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  // byte-addressed memory model
  logic [7:0]    mb [64];
  int            ack_delay = 0;
  int            wcnt = 0;
  int            acc_cnt = 0;
  int            hold_bad = 0;
  logic [AW-1:0] acc_addr [4];
  logic [3:0]    acc_be [4];
  logic [AW-1:0] h_addr = '0;
  logic [3:0]    h_be = '0;
  logic [31:0]   rtmp;

  function automatic int lane_pos(int l, logic bend);
    return bend ? 3 - l : l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt == 0) begin
        h_addr <= mem_addr;
        h_be   <= mem_be;
      end
      if (wcnt < ack_delay) begin
        wcnt <= wcnt + 1;
      end else begin
        wcnt    <= 0;
        mem_ack <= 1'b1;
        if (ack_delay > 0 && (mem_addr !== h_addr || mem_be !== h_be))
          hold_bad <= hold_bad + 1;
        for (int l = 0; l < 4; l++) begin
          rtmp[8*l +: 8] = mb[int'(mem_addr[5:2]) * 4 + lane_pos(l, cfg_big_end)];
          if (mem_we && mem_be[l])
            mb[int'(mem_addr[5:2]) * 4 + lane_pos(l, cfg_big_end)] <= mem_wdata[8*l +: 8];
        end
        mem_rdata <= rtmp;
        if (acc_cnt < 4) begin
          acc_addr[acc_cnt] <= mem_addr;
          acc_be[acc_cnt]   <= mem_be;
        end
        acc_cnt <= acc_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // results of the last access
  int            lat;
  logic          saw_trap;
  logic [63:0]   got_rd;
  logic [AW-1:0] got_taddr;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(int a, int s, logic bend);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < s; i++) begin
      if (bend) v[8*(s-1-i) +: 8] = mb[a+i];
      else      v[8*i +: 8]       = mb[a+i];
    end
    return v;
  endfunction

  task automatic run_acc(input logic we, input logic [1:0] sz, input int a,
                         input logic [63:0] wd, input logic split, input logic bend);
    @(negedge clk);
    cfg_split   = split;
    cfg_big_end = bend;
    req_write   = we;
    req_size    = sz;
    req_addr    = AW'(a);
    req_wdata   = wd;
    req_valid   = 1'b1;
    acc_cnt     = 0;
    hold_bad    = 0;
    lat         = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_done && !trap_valid && lat < 100);
    saw_trap  = trap_valid;
    got_rd    = req_rdata;
    got_taddr = trap_addr;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 mem_req in reset", 64'(mem_req), 64'd0);
    chk("R11 done in reset", 64'(req_done), 64'd0);
    chk("R11 trap in reset", 64'(trap_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {61'd0, mem_req, req_done, trap_valid}, 64'd0);
  endtask

  task automatic t_aligned_le;
    logic [63:0] e;
    e = exp_read(8, 4, 1'b0);
    run_acc(1'b0, 2'd2, 8, 64'd0, 1'b0, 1'b0);
    chk("R4 aligned word latency", 64'(lat), 64'd3);
    chk("R4 aligned word accesses", 64'(acc_cnt), 64'd1);
    chk("R6 word lanes", 64'(acc_be[0]), 64'hF);
    chk("R6 little-endian word value", got_rd, e);
    e = exp_read(32, 4, 1'b0);
    run_acc(1'b0, 2'd2, 32, 64'd0, 1'b1, 1'b0);
    chk("R4 aligned in split mode latency", 64'(lat), 64'd3);
    chk("R4 aligned in split mode accesses", 64'(acc_cnt), 64'd1);
  endtask

  task automatic t_narrow_be;
    logic [63:0] e;
    e = exp_read(5, 1, 1'b1);
    run_acc(1'b0, 2'd0, 5, 64'd0, 1'b0, 1'b1);
    chk("R7 byte lane at addr 5", 64'(acc_be[0]), 64'h4);
    chk("R9 byte zero-extended", got_rd, e);
    e = exp_read(10, 2, 1'b1);
    run_acc(1'b0, 2'd1, 10, 64'd0, 1'b0, 1'b1);
    chk("R7 half lanes at addr 10", 64'(acc_be[0]), 64'h3);
    chk("R7 big-endian half value", got_rd, e);
    chk("R1 byte at odd address not trapped", 64'(saw_trap), 64'd0);
  endtask

  task automatic t_traps;
    run_acc(1'b0, 2'd1, 3, 64'd0, 1'b0, 1'b0);
    chk("R2 half at 3 traps", 64'(saw_trap), 64'd1);
    chk("R2 trap latency", 64'(lat), 64'd1);
    chk("R2 trap address", 64'(got_taddr), 64'd3);
    repeat (3) @(negedge clk);
    chk("R2 no access after trap", 64'(acc_cnt), 64'd0);
    run_acc(1'b1, 2'd2, 6, 64'h5555, 1'b0, 1'b0);
    chk("R2 word write at 6 traps", 64'(saw_trap), 64'd1);
    chk("R2 trapped write no access", 64'(acc_cnt), 64'd0);
    run_acc(1'b0, 2'd3, 4, 64'd0, 1'b0, 1'b0);
    chk("R1 double at 4 is misaligned", 64'(saw_trap), 64'd1);
  endtask

  task automatic t_double_aligned;
    logic [63:0] e;
    e = exp_read(8, 8, 1'b0);
    run_acc(1'b0, 2'd3, 8, 64'd0, 1'b0, 1'b0);
    chk("R1 double at 8 not trapped", 64'(saw_trap), 64'd0);
    chk("R5 double uses two accesses", 64'(acc_cnt), 64'd2);
    chk("R5 double latency", 64'(lat), 64'd5);
    chk("R6 little-endian double value", got_rd, e);
  endtask

  task automatic t_split_write_le;
    logic [7:0] b6, b9;
    b6 = mb[6];
    b9 = mb[9];
    run_acc(1'b1, 2'd1, 7, 64'hBEEF, 1'b1, 1'b0);
    chk("R3 split write latency", 64'(lat), 64'd5);
    chk("R3 split write accesses", 64'(acc_cnt), 64'd2);
    chk("R3 first word lower", 64'(acc_addr[0]), 64'd4);
    chk("R3 second word next", 64'(acc_addr[1]), 64'd8);
    chk("R8 first enables", 64'(acc_be[0]), 64'h8);
    chk("R8 second enables", 64'(acc_be[1]), 64'h1);
    chk("R6 low byte at addr 7", 64'(mb[7]), 64'hEF);
    chk("R6 high byte at addr 8", 64'(mb[8]), 64'hBE);
    chk("R8 byte below untouched", 64'(mb[6]), 64'(b6));
    chk("R8 byte above untouched", 64'(mb[9]), 64'(b9));
    run_acc(1'b0, 2'd1, 7, 64'd0, 1'b1, 1'b0);
    chk("R9 split read back", got_rd, 64'hBEEF);
  endtask

  task automatic t_split_read_be;
    logic [63:0] e;
    e = exp_read(19, 8, 1'b1);
    run_acc(1'b0, 2'd3, 19, 64'd0, 1'b1, 1'b1);
    chk("R3 three-word latency", 64'(lat), 64'd7);
    chk("R3 three accesses", 64'(acc_cnt), 64'd3);
    chk("R3 order word 0", 64'(acc_addr[0]), 64'h10);
    chk("R3 order word 1", 64'(acc_addr[1]), 64'h14);
    chk("R3 order word 2", 64'(acc_addr[2]), 64'h18);
    chk("R7 enables word 0", 64'(acc_be[0]), 64'h1);
    chk("R7 enables word 1", 64'(acc_be[1]), 64'hF);
    chk("R7 enables word 2", 64'(acc_be[2]), 64'hE);
    chk("R9 big-endian double value", got_rd, e);
  endtask

  task automatic t_split_write_be;
    run_acc(1'b1, 2'd2, 30, 64'h11223344, 1'b1, 1'b1);
    chk("R8 enables word 0x1C", 64'(acc_be[0]), 64'h3);
    chk("R8 enables word 0x20", 64'(acc_be[1]), 64'hC);
    chk("R7 msb at lowest address",
        {32'd0, mb[30], mb[31], mb[32], mb[33]}, 64'h11223344);
  endtask

  task automatic t_slow_ack;
    logic [63:0] e;
    e = exp_read(3, 2, 1'b0);
    ack_delay = 3;
    run_acc(1'b0, 2'd1, 3, 64'd0, 1'b1, 1'b0);
    ack_delay = 0;
    chk("R10 slow split latency", 64'(lat), 64'd11);
    chk("R10 request held until ack", 64'(hold_bad), 64'd0);
    chk("R9 slow split value", got_rd, e);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mb[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    t_reset();
    t_aligned_le();
    t_narrow_be();
    t_traps();
    t_double_aligned();
    t_split_write_le();
    t_split_read_be();
    t_split_write_be();
    t_slow_ack();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule